// File: doc/BRIEF.md
# Event-Driven Thread Context Scheduler

This block decides which of several hardware thread contexts owns a shared execution pipeline. It keeps a resume address and a four-state status for each context, follows the running context's program counter as instructions issue, and moves the pipeline to another context when the running one has to wait. The datapath, the per-context register banks and the memory system sit outside. The register bank in use is simply the bank that `cur_ctx` selects.

A context gives up the pipeline in one of two ways. The first is a load that carries a switch hint: the instruction after it (the delay slot) still issues in the same context, and the switch happens when that delay-slot instruction issues. The second is an arbitration instruction, which switches as soon as it issues. In both cases the context stores the address of its next instruction, goes to Wait, and stays there until its completion event arrives. The next context is chosen by round-robin, starting from the context after the one that just switched. When no context can run, the block raises `idle`, ignores issue, and restarts the first context that becomes runnable.

After reset, context 0 runs from the reset vector. Every other context stays dormant until it is given a start address.

Top module: `ctxsw_sched`

## Requirements
- R1: After reset, context 0 is Active with `cur_pc` equal to `RESET_PC`, every other context is Inactive, `run_valid` is 1 and `idle` is 0. The status of context i is read from `ctx_status[2i+1:2i]` with the codes 0 Inactive, 1 Ready, 2 Active, 3 Wait.
- R2: When an ordinary instruction issues while a context is running, `cur_pc` takes `issue_next_pc` on the next cycle and the context does not change.
- R3: A switch-hinted load does not switch. The next instruction to issue is its delay slot and still belongs to the same context. When the delay slot issues, the context saves that instruction's `issue_next_pc` as its resume address and goes to Wait.
- R4: An arbitration instruction that is not in a delay slot switches in the cycle it issues. The context saves its `issue_next_pc` and goes to Wait.
- R5: On a switch, or on any cycle while idle, the new context is the first runnable context found by searching upward (with wrap-around) from the index after `cur_ctx`. A runnable context is one that is Ready, or one that is Wait with its event asserted.
- R6: The chosen context becomes Active. On the next cycle `cur_ctx` names it and `cur_pc` equals its saved resume address.
- R7: When no context is runnable at a switch, `idle` becomes 1 and `run_valid` becomes 0. While idle, issue inputs have no effect, and `cur_ctx` and `cur_pc` hold their values.
- R8: An asserted `ctx_event` bit moves a Wait context to Ready. While idle, the first woken context in round-robin order becomes Active on the next cycle.
- R9: A `ctx_event` bit for a context that is Inactive, Ready or Active (and not switching that cycle) is ignored.
- R10: If a context's event arrives in the same cycle as its own switch, the context does not go to Wait. It becomes Ready, or Active again if it is the only runnable context.
- R11: A start (`start_valid` with `start_ctx` and `start_pc`) makes an Inactive context Ready with `start_pc` as its resume address. A start to a context that is not Inactive is ignored.
- R12: At most one context is Active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction of the running context issues this cycle |
| issue_ld_switch | input | 1 | The issuing instruction is a switch-hinted load |
| issue_arb | input | 1 | The issuing instruction is an arbitration (voluntary yield) |
| issue_next_pc | input | PC_W | Address of the instruction that follows the issuing one |
| ctx_event | input | NUM_CTX | Completion event, one bit per context |
| start_valid | input | 1 | Post a start to a dormant context |
| start_ctx | input | CTX_W | Context that receives the start |
| start_pc | input | PC_W | Start address for that context |
| run_valid | output | 1 | A context owns the pipeline and may issue |
| idle | output | 1 | No context is running |
| cur_ctx | output | CTX_W | Running context; also selects its register bank |
| cur_pc | output | PC_W | Fetch address of the running context |
| ctx_status | output | 2*NUM_CTX | Two-bit status per context |

## Verification
The bench targets the delay slot. A design that switched on the hinted load itself would change `cur_ctx` one instruction early, and one that saved the load's address would later resume a context at the delay slot instead of after it. Events that arrive in the same cycle as their context's own switch are also checked. A design that let Wait override the event would strand that context, and with no other runnable context it would fall idle instead of resuming at once. Round-robin order is tested with several runnable contexts at once, both at a switch and while idle. Events and starts sent to contexts in the wrong state are shown to leave the status word unchanged.

// File: rtl/ctxsw_pkg.sv
// Shared types for the context scheduler.
// Assumes: status codes are exported on ports, so their values are fixed.
package ctxsw_pkg;
    typedef enum logic [1:0] {
        CTX_INACTIVE = 2'd0,
        CTX_READY    = 2'd1,
        CTX_ACTIVE   = 2'd2,
        CTX_WAIT     = 2'd3
    } ctx_state_e;
endpackage

// File: rtl/ctxsw_rr_pick.sv
// Round-robin picker: returns the first set request found by scanning upward
// from index `base`, wrapping at N. Purely combinational.
// Assumes: base < N.
module ctxsw_rr_pick #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] base,
    output logic         gnt_vld,
    output logic [W-1:0] gnt_idx
);
    int idx;

    // Scan from base and keep the first requester.
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        idx     = 0;
        for (int i = 0; i < N; i++) begin
            idx = (int'(base) + i) % N;
            if (!gnt_vld && req[idx[W-1:0]]) begin
                gnt_vld = 1'b1;
                gnt_idx = idx[W-1:0];
            end
        end
    end
endmodule

// File: rtl/ctxsw_slot.sv
// One context slot: holds its status and resume address.
// Assumes: save_i only for the running context; grant_i only when cand_o.
module ctxsw_slot
    import ctxsw_pkg::*;
#(
    parameter int              PC_W    = 16,
    parameter bit              BOOT    = 1'b0,
    parameter logic [PC_W-1:0] BOOT_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_i,
    input  logic             start_i,
    input  logic [PC_W-1:0]  start_pc_i,
    input  logic             save_i,
    input  logic [PC_W-1:0]  save_pc_i,
    input  logic             grant_i,
    output ctx_state_e       state_o,
    output logic [PC_W-1:0]  pc_o,
    output logic             cand_o
);
    // Runnable now: ready, waking from wait, or woken during its own switch.
    assign cand_o = (state_o == CTX_READY) ||
                    ((state_o == CTX_WAIT) && ev_i) ||
                    (save_i && ev_i);

    // Status and resume address update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= BOOT ? CTX_ACTIVE : CTX_INACTIVE;
            pc_o    <= BOOT ? BOOT_PC : '0;
        end else if (grant_i) begin
            state_o <= CTX_ACTIVE;
            if (save_i) pc_o <= save_pc_i;
        end else if (save_i) begin
            state_o <= ev_i ? CTX_READY : CTX_WAIT;
            pc_o    <= save_pc_i;
        end else begin
            case (state_o)
                CTX_WAIT:     if (ev_i) state_o <= CTX_READY;
                CTX_INACTIVE: if (start_i) begin
                    state_o <= CTX_READY;
                    pc_o    <= start_pc_i;
                end
                default: ;
            endcase
        end
    end

    // R3: a switch without a coincident event parks the context in Wait.
    assert_save_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && !ev_i && !grant_i) |=> (state_o == CTX_WAIT));
    // R10: an event in the switch cycle keeps the context out of Wait.
    assert_same_cycle_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && ev_i) |=> (state_o != CTX_WAIT));
    // R8: a waiting context leaves Wait when its event arrives.
    assert_event_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == CTX_WAIT) && !save_i && ev_i) |=> (state_o != CTX_WAIT));
    // R9: an Active context stays Active unless it switches.
    assert_active_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == CTX_ACTIVE) && !save_i) |=> (state_o == CTX_ACTIVE));
    // R11: only a start leaves Inactive.
    assert_dormant_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == CTX_INACTIVE) && !start_i) |=> (state_o == CTX_INACTIVE));
endmodule

// File: rtl/ctxsw_sched.sv
// Context scheduler top: tracks the running context and its PC, detects
// switch points (delay slot after a switch-hinted load, or an arbitration
// instruction), and hands the pipeline to the next runnable context.
// Assumes: a delay-slot instruction is neither a hinted load nor an arbitration.
module ctxsw_sched
    import ctxsw_pkg::*;
#(
    parameter int              NUM_CTX  = 8,
    parameter int              PC_W     = 16,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    localparam int             CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic                 issue_ld_switch,
    input  logic                 issue_arb,
    input  logic [PC_W-1:0]      issue_next_pc,
    input  logic [NUM_CTX-1:0]   ctx_event,
    input  logic                 start_valid,
    input  logic [CTX_W-1:0]     start_ctx,
    input  logic [PC_W-1:0]      start_pc,
    output logic                 run_valid,
    output logic                 idle,
    output logic [CTX_W-1:0]     cur_ctx,
    output logic [PC_W-1:0]      cur_pc,
    output logic [2*NUM_CTX-1:0] ctx_status
);
    logic               run_q;
    logic               slot_q;
    logic [CTX_W-1:0]   cur_q;
    logic [PC_W-1:0]    pc_q;
    logic               issue_ok;
    logic               do_switch;
    logic               do_pick;
    logic [CTX_W-1:0]   base;
    logic [NUM_CTX-1:0] cand;
    logic [NUM_CTX-1:0] active_vec;
    logic               gnt_vld;
    logic [CTX_W-1:0]   gnt_idx;
    ctx_state_e         slot_st [NUM_CTX];
    logic [PC_W-1:0]    slot_pc [NUM_CTX];

    // Switch-point detection and pick enable.
    assign issue_ok  = run_q && issue_valid;
    assign do_switch = issue_ok && (slot_q || issue_arb);
    assign do_pick   = do_switch || !run_q;
    assign base      = (cur_q == CTX_W'(NUM_CTX - 1)) ? '0 : cur_q + 1'b1;

    ctxsw_rr_pick #(.N(NUM_CTX)) pick_i (
        .req     (cand),
        .base    (base),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
        ctxsw_slot #(
            .PC_W    (PC_W),
            .BOOT    (i == 0),
            .BOOT_PC (RESET_PC)
        ) slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .ev_i       (ctx_event[i]),
            .start_i    (start_valid && (start_ctx == CTX_W'(i))),
            .start_pc_i (start_pc),
            .save_i     (do_switch && (cur_q == CTX_W'(i))),
            .save_pc_i  (issue_next_pc),
            .grant_i    (do_pick && gnt_vld && (gnt_idx == CTX_W'(i))),
            .state_o    (slot_st[i]),
            .pc_o       (slot_pc[i]),
            .cand_o     (cand[i])
        );
        assign ctx_status[2*i +: 2] = slot_st[i];
        assign active_vec[i]        = (slot_st[i] == CTX_ACTIVE);
    end

    // Running context, its fetch PC and the pending delay-slot flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b1;
            slot_q <= 1'b0;
            cur_q  <= '0;
            pc_q   <= RESET_PC;
        end else if (do_pick) begin
            slot_q <= 1'b0;
            run_q  <= gnt_vld;
            if (gnt_vld) begin
                cur_q <= gnt_idx;
                pc_q  <= (do_switch && (gnt_idx == cur_q)) ? issue_next_pc
                                                           : slot_pc[gnt_idx];
            end
        end else if (issue_ok) begin
            pc_q <= issue_next_pc;
            if (issue_ld_switch) slot_q <= 1'b1;
        end
    end

    assign run_valid = run_q;
    assign idle      = !run_q;
    assign cur_ctx   = cur_q;
    assign cur_pc    = pc_q;

    // R12: never two Active contexts.
    assert_single_active_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(active_vec) <= 1);
    // R6: while running, the named context is the Active one.
    assert_cur_is_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (slot_st[cur_q] == CTX_ACTIVE));
    // R5: the picker only grants a runnable context.
    assert_grant_runnable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> cand[gnt_idx]);
    // R3: a hinted load keeps the same context for its delay slot.
    assert_delay_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && issue_ld_switch && !slot_q && !issue_arb)
        |=> (run_q && (cur_q == $past(cur_q))));
    // R8: while idle, a runnable context resumes on the next cycle.
    assert_idle_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && gnt_vld) |=> run_q);
endmodule

// File: tb/ctxsw_sched_tb_top.sv
// Bench: a vector table walked once, then directed reset checks.
module ctxsw_sched_tb_top;
    localparam int NC = 4;

    typedef struct packed {
        logic        iv;
        logic        sw;
        logic        arb;
        logic [15:0] npc;
        logic [3:0]  ev;
        logic        stv;
        logic [1:0]  stc;
        logic [15:0] stpc;
        logic [1:0]  xctx;
        logic [15:0] xpc;
        logic        xidle;
        logic [7:0]  xstat;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    // Status per context i in bits [2i+1:2i]: 0 Inactive 1 Ready 2 Active 3 Wait.
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,16'h0000,4'b0000,1'b1,2'd1,16'h0200,2'd0,16'h0100,1'b0,8'h06,8'd11}, // R11 start ctx1
        '{1'b1,1'b0,1'b0,16'h0101,4'b0000,1'b1,2'd2,16'h0300,2'd0,16'h0101,1'b0,8'h16,8'd2},  // R2 plain issue
        '{1'b1,1'b1,1'b0,16'h0102,4'b0000,1'b0,2'd0,16'h0000,2'd0,16'h0102,1'b0,8'h16,8'd3},  // R3 hinted load
        '{1'b1,1'b0,1'b0,16'h0103,4'b0000,1'b0,2'd0,16'h0000,2'd1,16'h0200,1'b0,8'h1B,8'd3},  // R3 delay slot switches
        '{1'b1,1'b0,1'b0,16'h0201,4'b0001,1'b0,2'd0,16'h0000,2'd1,16'h0201,1'b0,8'h19,8'd8},  // R8 wake ctx0
        '{1'b1,1'b0,1'b1,16'h0202,4'b1100,1'b0,2'd0,16'h0000,2'd2,16'h0300,1'b0,8'h2D,8'd9},  // R9 R4 stray events
        '{1'b1,1'b0,1'b1,16'h0301,4'b0000,1'b0,2'd0,16'h0000,2'd0,16'h0103,1'b0,8'h3E,8'd5},  // R5 wrap skip inactive
        '{1'b1,1'b0,1'b1,16'h0104,4'b0001,1'b0,2'd0,16'h0000,2'd0,16'h0104,1'b0,8'h3E,8'd10}, // R10 self wake
        '{1'b1,1'b0,1'b1,16'h0105,4'b0000,1'b0,2'd0,16'h0000,2'd0,16'h0104,1'b1,8'h3F,8'd7},  // R7 go idle
        '{1'b1,1'b1,1'b0,16'h0999,4'b0000,1'b0,2'd0,16'h0000,2'd0,16'h0104,1'b1,8'h3F,8'd7},  // R7 issue ignored
        '{1'b0,1'b0,1'b0,16'h0000,4'b0110,1'b0,2'd0,16'h0000,2'd1,16'h0202,1'b0,8'h1B,8'd8},  // R8 resume RR
        '{1'b1,1'b1,1'b0,16'h0203,4'b0000,1'b0,2'd0,16'h0000,2'd1,16'h0203,1'b0,8'h1B,8'd3},  // R3 hinted load
        '{1'b1,1'b0,1'b0,16'h0204,4'b0010,1'b0,2'd0,16'h0000,2'd2,16'h0301,1'b0,8'h27,8'd10}, // R10 event at switch
        '{1'b0,1'b0,1'b0,16'h0000,4'b0000,1'b1,2'd2,16'h0777,2'd2,16'h0301,1'b0,8'h27,8'd11}, // R11 start ignored
        '{1'b1,1'b0,1'b1,16'h0302,4'b0000,1'b0,2'd0,16'h0000,2'd1,16'h0204,1'b0,8'h3B,8'd6},  // R6 resume after slot
        '{1'b0,1'b0,1'b0,16'h0000,4'b0000,1'b1,2'd3,16'h0400,2'd1,16'h0204,1'b0,8'h7B,8'd11}, // R11 start ctx3
        '{1'b1,1'b0,1'b1,16'h0205,4'b0000,1'b0,2'd0,16'h0000,2'd3,16'h0400,1'b0,8'hBF,8'd5}   // R5 pick ctx3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0, issue_ld_switch = 1'b0, issue_arb = 1'b0;
    logic [15:0] issue_next_pc = '0;
    logic [3:0]  ctx_event = '0;
    logic        start_valid = 1'b0;
    logic [1:0]  start_ctx = '0;
    logic [15:0] start_pc = '0;
    logic        run_valid, idle;
    logic [1:0]  cur_ctx;
    logic [15:0] cur_pc;
    logic [7:0]  ctx_status;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = !clk;  // 200 MHz

    ctxsw_sched #(.NUM_CTX(NC), .PC_W(16), .RESET_PC(16'h0100)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .issue_ld_switch(issue_ld_switch), .issue_arb(issue_arb),
        .issue_next_pc(issue_next_pc), .ctx_event(ctx_event),
        .start_valid(start_valid), .start_ctx(start_ctx), .start_pc(start_pc),
        .run_valid(run_valid), .idle(idle), .cur_ctx(cur_ctx), .cur_pc(cur_pc),
        .ctx_status(ctx_status)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int n_active(input logic [7:0] st);
        int n = 0;
        for (int k = 0; k < NC; k++) if (st[2*k +: 2] == 2'd2) n++;
        return n;
    endfunction

    task automatic check_reset_state(input string tag);
        chk({"R1 ", tag}, "cur_ctx", 32'(cur_ctx), 32'd0);
        chk({"R1 ", tag}, "cur_pc", 32'(cur_pc), 32'h0100);
        chk({"R1 ", tag}, "status", 32'(ctx_status), 32'h02);
        chk({"R1 ", tag}, "run/idle", {30'd0, run_valid, idle}, 32'b10);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_reset_state("after reset");
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            issue_valid     = VECS[v].iv;
            issue_ld_switch = VECS[v].sw;
            issue_arb       = VECS[v].arb;
            issue_next_pc   = VECS[v].npc;
            ctx_event       = VECS[v].ev;
            start_valid     = VECS[v].stv;
            start_ctx       = VECS[v].stc;
            start_pc        = VECS[v].stpc;
            @(posedge clk);
            #1;
            chk($sformatf("R%0d vec %0d", VECS[v].req, v), "cur_ctx", 32'(cur_ctx), 32'(VECS[v].xctx));
            chk($sformatf("R%0d vec %0d", VECS[v].req, v), "cur_pc", 32'(cur_pc), 32'(VECS[v].xpc));
            chk($sformatf("R%0d vec %0d", VECS[v].req, v), "idle", 32'(idle), 32'(VECS[v].xidle));
            chk($sformatf("R%0d vec %0d", VECS[v].req, v), "status", 32'(ctx_status), 32'(VECS[v].xstat));
            chk($sformatf("R12 vec %0d", v), "active count <= 1",
                32'(n_active(ctx_status) <= 1), 32'd1);
            chk($sformatf("R7 vec %0d", v), "run_valid vs idle", 32'(run_valid), 32'(!VECS[v].xidle));
        end
        // Directed: reset mid-run restores R1 state.
        @(negedge clk);
        issue_valid = 1'b0; issue_ld_switch = 1'b0; issue_arb = 1'b0;
        ctx_event = '0; start_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_reset_state("mid-run reset");
        // Directed R1/R11: event to a dormant context after reset is ignored.
        @(negedge clk);
        ctx_event = 4'b1110;
        @(posedge clk);
        #1;
        chk("R9 dormant event", "status", 32'(ctx_status), 32'h02);
        @(negedge clk);
        ctx_event = '0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule